// File: doc/BRIEF.md
# Multi-Source Wake-Up Event Router

The router watches up to twenty single-bit event lines from on-chip sources. These include wake-up pins, alarm and real-time timers, a brown-out monitor, a watchdog, communication controllers, timer outputs and a reset indication. Each implemented slot has its own detector. The detector looks either for a level or for a transition, and a two-bit mode chooses which, together with its direction. A detected event latches a sticky status flag. Each slot also has a per-slot enable, and the block raises one registered wake-up line whenever an enabled flag is set.

Software reaches the block through a small word-addressed register port. Mode bits are plain read/write registers. Status and enable are read-only images, and they change only through dedicated write-one-to-set and write-one-to-clear offsets, so no read-modify-write is ever needed. Slot positions 17 and 18 are holes: they hold no state, read as zero and ignore writes. Every input is assumed to be synchronous to the block clock.

Top module: `er_wake_router`

## Requirements
- R1: Slots 17 and 18 are unimplemented: their bits read 0 at every offset, and writes and input events on them change nothing.
- R2: The polarity register (offset 0) and the detect-style register (offset 1) are read/write, reset to 0, and store only implemented bits.
- R3: Each slot detects according to its style and polarity bits. Style 0 with polarity 0 detects a low level, style 0 with polarity 1 a high level, style 1 with polarity 0 a falling edge, and style 1 with polarity 1 a rising edge. A detection sets the status bit at the next clock edge.
- R4: After reset, every implemented status bit is 1, every enable bit is 0 and the wake output is 0.
- R5: Writing 1s to offset 3 sets the matching enable bits and writing 1s to offset 2 clears them. Zero bits have no effect, and a write to the enable image (offset 5) changes nothing.
- R6: Writing 1s to offset 7 sets the matching status bits and writing 1s to offset 6 clears them. A write to the status image (offset 4) changes nothing.
- R7: When a detection and a software clear hit the same status bit in the same cycle, the bit stays 1. In level mode, a bit whose active level persists cannot be cleared.
- R8: The wake output is a register holding the OR of (status AND enable) from the previous cycle, so it follows a status or enable change one clock later.
- R9: Offset 4 reads the status and offset 5 reads the enable; offsets 2, 3, 6 and 7 read as zero.
- R10: Edge detection compares the input with its value on the previous clock, so an input held at its active level after a clear does not set the status bit again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_in | input | NUM_SLOTS | Event lines, one per slot, synchronous to clk |
| reg_wr | input | 1 | Register write strobe for the current cycle |
| reg_addr | input | 3 | Word offset of the register access |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for reg_addr |
| wake_out | output | 1 | Registered wake-up / interrupt request |

## Verification
The interesting collision is a hardware detection landing in the same clock edge as a software write to the clear-status offset for the same bit. The bench provokes it in two ways. First, it drives a rising transition on a slot at the same negative edge that presents the clear write. Second, it holds a high level in level mode and issues the clear. In both cases the bit is judged by reading the status image afterwards and expecting 1. A second clear, issued once the transition has passed in edge mode, must then bring the bit to 0.

// File: rtl/er_pkg.sv
package er_pkg;

   // word offsets of the register port; the order is part of the software view
   typedef enum logic [2:0] {
      OFS_POL    = 3'd0,
      OFS_STYLE  = 3'd1,
      OFS_EN_CLR = 3'd2,
      OFS_EN_SET = 3'd3,
      OFS_ST_IMG = 3'd4,
      OFS_EN_IMG = 3'd5,
      OFS_ST_CLR = 3'd6,
      OFS_ST_SET = 3'd7
   } er_ofs_e;

   localparam int unsigned ER_OFS_W = 3;

endpackage

// File: rtl/er_mode_regs.sv
module er_mode_regs #(
   parameter int unsigned              N    = 20,
   parameter logic [N-1:0]             MASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_pol,
   input  logic         wr_style,
   input  logic [N-1:0] wdata,
   output logic [N-1:0] pol_q,
   output logic [N-1:0] style_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pol_q   <= '0;
         style_q <= '0;
      end else begin
         if (wr_pol)   pol_q   <= wdata & MASK;
         if (wr_style) style_q <= wdata & MASK;
      end
   end

   // R2: a write lands exactly, restricted to implemented slots
   p_pol_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pol |=> (pol_q == ($past(wdata) & MASK)));

   p_style_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_style |=> $stable(style_q));

endmodule

// File: rtl/er_detect.sv
module er_detect #(
   parameter int unsigned  N    = 20,
   parameter logic [N-1:0] MASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] ev_in,
   input  logic [N-1:0] pol,
   input  logic [N-1:0] style,
   output logic [N-1:0] hit
);

   for (genvar i = 0; i < N; i++) begin : g_slot
      if (MASK[i]) begin : g_live
         logic prev_q;
         logic at_level;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= ev_in[i];
         end

         assign at_level = (ev_in[i] == pol[i]);
         assign hit[i]   = style[i] ? (at_level && (ev_in[i] != prev_q)) : at_level;

         // R10: with mode unchanged, an edge hit is never followed by another hit
         p_edge_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (style[i] && hit[i]) |=> (!style[i] || !$stable(pol[i]) || !hit[i]));
      end else begin : g_hole
         logic unused_hole;
         assign unused_hole = ev_in[i] ^ pol[i] ^ style[i];
         assign hit[i]      = 1'b0;
      end
   end

endmodule

// File: rtl/er_flag_bank.sv
module er_flag_bank #(
   parameter int unsigned  N         = 20,
   parameter logic [N-1:0] MASK      = '1,
   parameter logic [N-1:0] RESET_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] hw_set,
   input  logic [N-1:0] sw_set,
   input  logic [N-1:0] sw_clr,
   output logic [N-1:0] q
);

   logic [N-1:0] nxt;

   // hardware set outranks software clear; software set and clear never share a write
   assign nxt = (hw_set | ((q | sw_set) & ~sw_clr)) & MASK;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RESET_VAL & MASK;
      else        q <= nxt;
   end

   p_hw_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (|(hw_set & MASK)) |=> ((q & $past(hw_set & MASK)) == $past(hw_set & MASK)));

   p_sw_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|(sw_clr & ~hw_set & MASK)) |=> ((q & $past(sw_clr & ~hw_set & MASK)) == '0));

   p_sw_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (|(sw_set & ~sw_clr & MASK)) |=> ((q & $past(sw_set & ~sw_clr & MASK)) == $past(sw_set & ~sw_clr & MASK)));

   p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_set == '0 && sw_set == '0 && sw_clr == '0) |=> $stable(q));

endmodule

// File: rtl/er_wake_out.sv
module er_wake_out #(
   parameter int unsigned N = 20
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] status,
   input  logic [N-1:0] enable,
   output logic         wake
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wake <= 1'b0;
      else        wake <= |(status & enable);
   end

endmodule

// File: rtl/er_wake_router.sv
module er_wake_router
   import er_pkg::*;
#(
   parameter int unsigned          NUM_SLOTS = 20,
   parameter logic [NUM_SLOTS-1:0] IMPL_MASK = 20'h9FFFF,
   parameter int unsigned          DATA_W    = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_SLOTS-1:0]  ev_in,
   input  logic                  reg_wr,
   input  logic [ER_OFS_W-1:0]   reg_addr,
   input  logic [DATA_W-1:0]     reg_wdata,
   output logic [DATA_W-1:0]     reg_rdata,
   output logic                  wake_out
);

   localparam int unsigned PAD_W = DATA_W - NUM_SLOTS;

   if (NUM_SLOTS < 1) begin : g_bad_slots
      $error("er_wake_router: NUM_SLOTS must be at least 1");
   end
   if (DATA_W < NUM_SLOTS) begin : g_bad_width
      $error("er_wake_router: DATA_W must cover NUM_SLOTS");
   end

   er_ofs_e              ofs;
   logic [NUM_SLOTS-1:0] wbits;
   logic [NUM_SLOTS-1:0] pol_q, style_q, hit, st_q, en_q;
   logic [NUM_SLOTS-1:0] en_set, en_clr, st_set, st_clr;

   assign ofs   = er_ofs_e'(reg_addr);
   assign wbits = reg_wdata[NUM_SLOTS-1:0];

   if (PAD_W > 0) begin : g_pad
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^reg_wdata[DATA_W-1:NUM_SLOTS];
   end

   assign en_set = (reg_wr && ofs == OFS_EN_SET) ? wbits : '0;
   assign en_clr = (reg_wr && ofs == OFS_EN_CLR) ? wbits : '0;
   assign st_set = (reg_wr && ofs == OFS_ST_SET) ? wbits : '0;
   assign st_clr = (reg_wr && ofs == OFS_ST_CLR) ? wbits : '0;

   er_mode_regs #(.N(NUM_SLOTS), .MASK(IMPL_MASK)) u_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_pol   (reg_wr && ofs == OFS_POL),
      .wr_style (reg_wr && ofs == OFS_STYLE),
      .wdata    (wbits),
      .pol_q    (pol_q),
      .style_q  (style_q)
   );

   er_detect #(.N(NUM_SLOTS), .MASK(IMPL_MASK)) u_detect (
      .clk   (clk),
      .rst_n (rst_n),
      .ev_in (ev_in),
      .pol   (pol_q),
      .style (style_q),
      .hit   (hit)
   );

   er_flag_bank #(.N(NUM_SLOTS), .MASK(IMPL_MASK), .RESET_VAL('1)) u_status (
      .clk    (clk),
      .rst_n  (rst_n),
      .hw_set (hit),
      .sw_set (st_set),
      .sw_clr (st_clr),
      .q      (st_q)
   );

   er_flag_bank #(.N(NUM_SLOTS), .MASK(IMPL_MASK), .RESET_VAL('0)) u_enable (
      .clk    (clk),
      .rst_n  (rst_n),
      .hw_set ('0),
      .sw_set (en_set),
      .sw_clr (en_clr),
      .q      (en_q)
   );

   er_wake_out #(.N(NUM_SLOTS)) u_wake (
      .clk    (clk),
      .rst_n  (rst_n),
      .status (st_q),
      .enable (en_q),
      .wake   (wake_out)
   );

   always_comb begin
      reg_rdata = '0;
      unique case (ofs)
         OFS_POL:    reg_rdata[NUM_SLOTS-1:0] = pol_q;
         OFS_STYLE:  reg_rdata[NUM_SLOTS-1:0] = style_q;
         OFS_ST_IMG: reg_rdata[NUM_SLOTS-1:0] = st_q;
         OFS_EN_IMG: reg_rdata[NUM_SLOTS-1:0] = en_q;
         default:    reg_rdata = '0;
      endcase
   end

   // R8: wake output trails the gated status by exactly one clock
   p_wake_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (wake_out == $past(|(st_q & en_q))));

   // R3: every detection is visible in the status image one clock later
   p_hit_latched_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|hit) |=> ((st_q & $past(hit)) == $past(hit)));

endmodule

// File: tb/test_er_wake_router.sv
module test_er_wake_router;

   localparam int unsigned N = 20;
   localparam logic [31:0] MASK = ((32'd1 << 17) - 32'd1) | (32'd1 << 19);
   localparam logic [31:0] ALL  = (32'd1 << N) - 32'd1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [N-1:0] ev_in = '0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        wake_out;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #5 clk = ~clk;

   er_wake_router i_er_wake_router (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev_in     (ev_in),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .wake_out  (wake_out)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      #1 reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R4 reset state, R2 mode reset
      rd(3'd4, v); chk("R4 status reset", v, MASK);
      rd(3'd5, v); chk("R4 enable reset", v, 32'h0);
      chk("R4 wake reset", {31'h0, wake_out}, 32'h0);
      rd(3'd0, v); chk("R2 polarity reset", v, 32'h0);
      rd(3'd1, v); chk("R2 style reset", v, 32'h0);

      // R9 write-only offsets read zero
      for (int a = 2; a < 8; a++) begin
         if (a == 4 || a == 5) continue;
         rd(3'(a), v); chk($sformatf("R9 offset %0d reads zero", a), v, 32'h0);
      end

      // R1/R2 mode registers keep only implemented bits
      wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, v); chk("R1 R2 polarity mask", v, MASK);
      wr(3'd1, 32'h0005_A5A5); rd(3'd1, v); chk("R2 style readback", v, 32'h0005_A5A5 & MASK);

      // R3 sweep: every mode on every slot, including the holes (R1)
      for (int m = 0; m < 4; m++) begin
         logic [N-1:0] idle;
         logic [31:0] pv, sv;
         pv = (m & 1) ? ALL : 32'h0;
         sv = (m & 2) ? ALL : 32'h0;
         idle = (m & 1) ? '0 : '1;
         @(negedge clk); ev_in = idle;
         wr(3'd0, pv);
         wr(3'd1, sv);
         @(negedge clk);
         wr(3'd6, ALL);
         rd(3'd4, v); chk($sformatf("R3 mode %0d idle clear", m), v, 32'h0);
         for (int i = 0; i < N; i++) begin
            @(negedge clk); ev_in[i] = ~idle[i];
            @(negedge clk); ev_in[i] = idle[i];
            @(negedge clk);
            rd(3'd4, v);
            chk($sformatf("R3 R1 mode %0d slot %0d", m, i), v, MASK & (32'd1 << i));
            wr(3'd6, ALL);
         end
      end

      // R10 held input in rising mode does not retrigger after clear
      @(negedge clk); ev_in = '0;
      wr(3'd0, ALL); wr(3'd1, ALL);
      wr(3'd6, ALL);
      @(negedge clk); ev_in[2] = 1'b1;
      rd(3'd4, v); chk("R10 rising edge sets", v, 32'h4);
      wr(3'd6, 32'h4);
      repeat (3) @(negedge clk);
      rd(3'd4, v); chk("R10 held level no retrigger", v, 32'h0);
      @(negedge clk); ev_in[2] = 1'b0;

      // R7 same-cycle detection and clear: detection wins
      @(negedge clk);
      ev_in[5] = 1'b1;
      reg_wr = 1'b1; reg_addr = 3'd6; reg_wdata = 32'h20;
      @(posedge clk);
      #1 reg_wr = 1'b0; reg_wdata = '0;
      rd(3'd4, v); chk("R7 edge hit beats clear", v, 32'h20);
      wr(3'd6, 32'h20);
      rd(3'd4, v); chk("R7 later clear succeeds", v, 32'h0);
      @(negedge clk); ev_in[5] = 1'b0;

      // R7 level mode: persisting high level blocks the clear
      wr(3'd1, 32'h0);
      @(negedge clk); ev_in = '0; ev_in[3] = 1'b1;
      @(negedge clk);
      wr(3'd6, ALL);
      rd(3'd4, v); chk("R7 level persists through clear", v, 32'h8);
      @(negedge clk); ev_in[3] = 1'b0;
      wr(3'd6, ALL);
      rd(3'd4, v); chk("R7 clear after level drops", v, 32'h0);

      // R6 software set/clear of status, image write ignored
      wr(3'd1, ALL); // rising mode, inputs low: no detections
      wr(3'd7, 32'h0008_1001);
      rd(3'd4, v); chk("R6 set-status", v, 32'h0008_1001);
      wr(3'd4, 32'h0);
      rd(3'd4, v); chk("R6 status image write ignored", v, 32'h0008_1001);
      wr(3'd6, 32'h0000_1000);
      rd(3'd4, v); chk("R6 clear-status one bit", v, 32'h0008_0001);
      wr(3'd7, 32'h0006_0000);
      rd(3'd4, v); chk("R1 set-status on holes", v, 32'h0008_0001);

      // R5 enable set/clear
      wr(3'd3, 32'h0000_0005);
      rd(3'd5, v); chk("R5 set-enable", v, 32'h5);
      wr(3'd2, 32'h0000_0001);
      rd(3'd5, v); chk("R5 clear-enable", v, 32'h4);
      wr(3'd3, 32'h0); wr(3'd2, 32'h0);
      rd(3'd5, v); chk("R5 zero writes no effect", v, 32'h4);
      wr(3'd5, ALL);
      rd(3'd5, v); chk("R5 enable image write ignored", v, 32'h4);
      wr(3'd3, ALL);
      rd(3'd5, v); chk("R1 R5 set-enable holes", v, MASK);

      // R8 wake timing
      wr(3'd2, ALL);
      wr(3'd6, ALL);
      wr(3'd3, 32'h0008_0000);
      @(negedge clk);
      chk("R8 wake idle", {31'h0, wake_out}, 32'h0);
      wr(3'd7, 32'h0008_0000);
      chk("R8 wake one cycle late", {31'h0, wake_out}, 32'h0);
      @(posedge clk); #1;
      chk("R8 wake rises", {31'h0, wake_out}, 32'h1);
      wr(3'd7, 32'h0000_0010);
      wr(3'd2, 32'h0008_0000);
      chk("R8 wake before enable drop seen", {31'h0, wake_out}, 32'h1);
      @(posedge clk); #1;
      chk("R8 wake falls, unenabled status ignored", {31'h0, wake_out}, 32'h0);

      finish_run();
   end

endmodule